// File: doc/BRIEF.md
# Multi-Mode Register Shift Unit

This block holds an N-bit word (8 bits by default) and, on each enabled clock edge, moves it by one bit position using one of six shift kinds chosen by a three-bit select. The kinds are logical left and right, rotate left and right, and signed (arithmetic) left and right. A parallel load path replaces the whole word. A serial fill option lets the logical shifts take their incoming bit from an input pin instead of a constant zero.

The signed left shift doubles a two's-complement value. When the doubling cannot be represented, a sticky-free overflow flag is raised on the same edge that moves the word. The flag is cleared by every other shift kind and by a load. Unused select codes, and cycles without an enable, leave both the word and the flag untouched. The unit is a datapath slice that a sequencer drives one micro-step per cycle.

Top module: `shiftreg_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `data_out` to all zeros and `ovf_flag` to 0 on the next clock edge. Reset has priority over every other input.
- R2: When `load_en` is 1, the edge copies `load_word` into `data_out` and clears `ovf_flag`, whatever `shift_en` and `op_sel` are.
- R3: With `shift_en`=1 and `fill_use`=0, code 3'b000 moves every bit one place toward the MSB with 0 entering bit 0. Code 3'b001 moves every bit one place toward the LSB with 0 entering bit N-1.
- R4: With `fill_use`=1, codes 3'b000 and 3'b001 enter `fill_bit` at bit 0 and bit N-1 respectively. For every other code, `fill_use` and `fill_bit` have no effect.
- R5: Code 3'b010 rotates left: old bit N-1 enters bit 0. Code 3'b011 rotates right: old bit 0 enters bit N-1. No bit is lost.
- R6: Code 3'b101 is the arithmetic right shift. Bit N-1 keeps its value, every other bit takes the value of its upper neighbour, and the old bit 0 is dropped.
- R7: Code 3'b100 is the arithmetic left shift. 0 enters bit 0, each bit takes the value of its lower neighbour, and the old bit N-1 is replaced by the old bit N-2.
- R8: On code 3'b100, the same edge that shifts the word sets `ovf_flag` to 1 exactly when old bit N-1 differs from old bit N-2, and to 0 otherwise.
- R9: Codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b101 clear `ovf_flag` on the edge they shift.
- R10: Codes 3'b110 and 3'b111 with `shift_en`=1 leave both `data_out` and `ovf_flag` unchanged.
- R11: With `shift_en`=0 and `load_en`=0, both `data_out` and `ovf_flag` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load request, wins over shifting |
| load_word | input | WIDTH | Word copied in on a load |
| shift_en | input | 1 | Apply the selected shift on this edge |
| op_sel | input | 3 | Shift kind select (see R3 to R10) |
| fill_use | input | 1 | Logical shifts take their incoming bit from `fill_bit` |
| fill_bit | input | 1 | Serial incoming bit for logical shifts |
| data_out | output | WIDTH | Registered word |
| ovf_flag | output | 1 | Registered overflow of the last arithmetic left shift |

## Verification
The hardest state to reach from the ports is a set overflow flag followed by an operation that must either keep it (an unused code or an idle cycle) or clear it (a load or another shift kind). The stimulus loads words whose top two bits differ, applies an arithmetic left shift to raise the flag, and then applies each keeping or clearing operation in turn. Before each of these, the flag is raised again. A randomised sequence then mixes loads, idle cycles, every select code and both fill settings, and a reference model predicts each edge.

// File: rtl/shiftreg_pkg.sv
package shiftreg_pkg;

    typedef enum logic [2:0] {
        OP_SHL  = 3'b000,
        OP_SHR  = 3'b001,
        OP_ROTL = 3'b010,
        OP_ROTR = 3'b011,
        OP_ASHL = 3'b100,
        OP_ASHR = 3'b101
    } shift_op_e;

    localparam int OP_BITS = 3;

    function automatic logic op_is_known(input logic [OP_BITS-1:0] code);
        return code <= 3'b101;
    endfunction

endpackage

// File: rtl/sh_next_value.sv
module sh_next_value
    import shiftreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   cur_word,
    input  logic [OP_BITS-1:0] op,
    input  logic               fill_use,
    input  logic               fill_bit,
    output logic [WIDTH-1:0]   shifted,
    output logic               op_known
);
    logic      log_fill;
    logic      low_in;
    logic      high_in;
    logic      go_left;
    shift_op_e op_e;

    assign op_e     = shift_op_e'(op);
    assign log_fill = fill_use & fill_bit;
    assign op_known = op_is_known(op);

    always_comb begin
        low_in  = 1'b0;
        high_in = 1'b0;
        go_left = 1'b0;
        case (op_e)
            OP_SHL:  begin low_in  = log_fill;          go_left = 1'b1; end
            OP_ROTL: begin low_in  = cur_word[WIDTH-1]; go_left = 1'b1; end
            OP_ASHL: begin low_in  = 1'b0;              go_left = 1'b1; end
            OP_SHR:  high_in = log_fill;
            OP_ROTR: high_in = cur_word[0];
            OP_ASHR: high_in = cur_word[WIDTH-1];
            default: ;
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_lsb
            assign from_low = low_in;
        end else begin : g_mid_low
            assign from_low = cur_word[i-1];
        end
        if (i == WIDTH-1) begin : g_msb
            assign from_high = high_in;
        end else begin : g_mid_high
            assign from_high = cur_word[i+1];
        end
        assign shifted[i] = go_left ? from_low : from_high;
    end

endmodule

// File: rtl/sh_ovf_detect.sv
module sh_ovf_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_word,
    input  logic             is_ashl,
    output logic             ovf_new
);
    localparam int TOP  = WIDTH - 1;
    localparam int NEXT = WIDTH - 2;

    // Doubling changes the sign when the two top bits disagree.
    assign ovf_new = is_ashl & (cur_word[TOP] ^ cur_word[NEXT]);

endmodule

// File: rtl/shiftreg_unit.sv
module shiftreg_unit
    import shiftreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    input  logic             shift_en,
    input  logic [2:0]       op_sel,
    input  logic             fill_use,
    input  logic             fill_bit,
    output logic [WIDTH-1:0] data_out,
    output logic             ovf_flag
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             ovf;
    } state_t;

    state_t           st_q;
    state_t           st_d;
    logic [WIDTH-1:0] shifted_d;
    logic             known_d;
    logic             ovf_calc_d;

    sh_next_value #(.WIDTH(WIDTH)) u_next (
        .cur_word (st_q.word),
        .op       (op_sel),
        .fill_use (fill_use),
        .fill_bit (fill_bit),
        .shifted  (shifted_d),
        .op_known (known_d)
    );

    sh_ovf_detect #(.WIDTH(WIDTH)) u_ovf (
        .cur_word (st_q.word),
        .is_ashl  (op_sel == OP_ASHL),
        .ovf_new  (ovf_calc_d)
    );

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.word = load_word;
            st_d.ovf  = 1'b0;
        end else if (shift_en && known_d) begin
            st_d.word = shifted_d;
            st_d.ovf  = ovf_calc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out = st_q.word;
    assign ovf_flag = st_q.ovf;

endmodule

// File: rtl/shiftreg_unit_chk.sv
module shiftreg_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [WIDTH-1:0] load_word,
    input logic             shift_en,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] data_out,
    input logic             ovf_flag
);
    logic act;
    assign act = !load_en && shift_en;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (data_out == '0 && !ovf_flag));

    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (data_out == $past(load_word) && !ovf_flag));

    a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
        (act && (op_sel == 3'b010 || op_sel == 3'b011))
        |=> ($countones(data_out) == $countones($past(data_out))));

    a_r6_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (act && op_sel == 3'b101) |=> (data_out[WIDTH-1] == $past(data_out[WIDTH-1])));

    a_r7_zero_in_lsb: assert property (@(posedge clk) disable iff (rst)
        (act && op_sel == 3'b100) |=> (data_out[0] == 1'b0));

    a_r8_overflow_same_edge: assert property (@(posedge clk) disable iff (rst)
        (act && op_sel == 3'b100)
        |=> (ovf_flag == ($past(data_out[WIDTH-1]) ^ $past(data_out[WIDTH-2]))));

    a_r9_other_clear: assert property (@(posedge clk) disable iff (rst)
        (act && op_sel != 3'b100 && op_sel <= 3'b101) |=> !ovf_flag);

    a_r10_unused_hold: assert property (@(posedge clk) disable iff (rst)
        (act && op_sel >= 3'b110) |=> ($stable(data_out) && $stable(ovf_flag)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !shift_en) |=> ($stable(data_out) && $stable(ovf_flag)));

endmodule

bind shiftreg_unit shiftreg_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_word (load_word),
    .shift_en  (shift_en),
    .op_sel    (op_sel),
    .data_out  (data_out),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_shiftreg_unit.sv
module test_shiftreg_unit;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] word;
        logic         ovf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_en = 1'b0;
    logic [W-1:0] load_word = '0;
    logic         shift_en = 1'b0;
    logic [2:0]   op_sel = 3'b000;
    logic         fill_use = 1'b0;
    logic         fill_bit = 1'b0;
    logic [W-1:0] data_out;
    logic         ovf_flag;

    exp_t         sb[$];
    logic [W-1:0] m_word = '0;
    logic         m_ovf = 1'b0;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    shiftreg_unit #(.WIDTH(W)) i_shiftreg_unit (
        .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
        .shift_en(shift_en), .op_sel(op_sel), .fill_use(fill_use),
        .fill_bit(fill_bit), .data_out(data_out), .ovf_flag(ovf_flag)
    );

    task automatic step(input logic r, input logic ld, input logic [W-1:0] lw,
                        input logic en, input logic [2:0] op, input logic fu,
                        input logic fb, input string tag);
        logic fin;
        exp_t e;
        @(negedge clk);
        rst = r; load_en = ld; load_word = lw; shift_en = en;
        op_sel = op; fill_use = fu; fill_bit = fb;
        fin = fu ? fb : 1'b0;
        if (r) begin
            m_word = '0; m_ovf = 1'b0;
        end else if (ld) begin
            m_word = lw; m_ovf = 1'b0;
        end else if (en) begin
            case (op)
                3'b000: begin m_word = {m_word[W-2:0], fin}; m_ovf = 1'b0; end
                3'b001: begin m_word = {fin, m_word[W-1:1]}; m_ovf = 1'b0; end
                3'b010: begin m_word = {m_word[W-2:0], m_word[W-1]}; m_ovf = 1'b0; end
                3'b011: begin m_word = {m_word[0], m_word[W-1:1]}; m_ovf = 1'b0; end
                3'b100: begin m_ovf = m_word[W-1] ^ m_word[W-2];
                              m_word = {m_word[W-2:0], 1'b0}; end
                3'b101: begin m_word = {m_word[W-1], m_word[W-1:1]}; m_ovf = 1'b0; end
                default: ;
            endcase
        end
        e.word = m_word; e.ovf = m_ovf; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: each queued item is due just after the next rising edge.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_cmp++;
                if (data_out !== e.word || ovf_flag !== e.ovf) begin
                    n_bad++;
                    $display("FAIL %s: actual data=%h ovf=%b expected data=%h ovf=%b",
                             e.tag, data_out, ovf_flag, e.word, e.ovf);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'b000, 3'b001: return "R3";
            3'b010, 3'b011: return "R5";
            3'b100:         return "R8";
            3'b101:         return "R6";
            default:        return "R10";
        endcase
    endfunction

    initial begin
        step(1, 0, 8'h00, 0, 3'b000, 0, 0, "R1");
        step(1, 1, 8'hFF, 1, 3'b100, 0, 0, "R1");
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b000, 0, 0, "R3");      // 81 -> 02
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b001, 0, 0, "R3");      // 81 -> 40
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b000, 1, 1, "R4");      // 81 -> 03
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b001, 1, 1, "R4");      // 81 -> C0
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b010, 1, 0, "R4");      // fill ignored on rotate
        step(0, 0, 8'h00, 1, 3'b010, 0, 0, "R5");
        step(0, 0, 8'h00, 1, 3'b011, 0, 0, "R5");
        step(0, 0, 8'h00, 1, 3'b011, 0, 0, "R5");
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b101, 1, 0, "R6");      // 81 -> C0
        step(0, 1, 8'h40, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b101, 0, 0, "R6");      // 40 -> 20
        step(0, 0, 8'h00, 1, 3'b100, 1, 1, "R7");      // 20 -> 40, no ovf
        step(0, 0, 8'h00, 1, 3'b100, 0, 0, "R8");      // 40 -> 80, ovf
        step(0, 1, 8'hC0, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b100, 0, 0, "R8");      // C0 -> 80, no ovf
        step(0, 0, 8'h00, 1, 3'b100, 0, 0, "R8");      // 80 -> 00, ovf
        step(0, 0, 8'h00, 1, 3'b110, 0, 0, "R10");
        step(0, 0, 8'h00, 1, 3'b111, 1, 1, "R10");
        step(0, 0, 8'h00, 0, 3'b100, 0, 0, "R11");
        step(0, 1, 8'h5A, 1, 3'b100, 0, 0, "R2");      // load wins, clears flag
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b100, 0, 0, "R8");
        step(0, 0, 8'h00, 1, 3'b001, 0, 0, "R9");      // shift clears flag
        step(0, 1, 8'h81, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b100, 0, 0, "R8");
        step(0, 0, 8'h00, 1, 3'b011, 0, 0, "R9");
        step(0, 1, 8'h41, 0, 3'b000, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 3'b100, 0, 0, "R8");
        step(1, 0, 8'h00, 0, 3'b000, 0, 0, "R1");
        for (int k = 0; k < 400; k++) begin
            logic [2:0] op;
            int         sel;
            op  = 3'($urandom_range(0, 7));
            sel = $urandom_range(0, 9);
            if (sel == 0)
                step(0, 1, W'($urandom), $urandom_range(0, 1) == 1, op, 0, 0, "R2");
            else if (sel == 1)
                step(0, 0, W'($urandom), 0, op, 1, 1, "R11");
            else
                step(0, 0, 8'h00, 1, op, $urandom_range(0, 1) == 1,
                     $urandom_range(0, 1) == 1, op_tag(op));
        end
        step(0, 0, 8'h00, 0, 3'b000, 0, 0, "R11");
        wait (sb.size() == 0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule